// File: doc/BRIEF.md
# Approximate Value Compute Unit

This unit sits in front of a compressor and loosens the low-order bits of one 32-bit word so that nearby values become bit-identical and compress better. The caller supplies the word, a flag saying whether the word may be approximated, a select saying whether it is an unsigned integer or an IEEE 754 single-precision float, and an error threshold expressed as a right-shift amount. A threshold of e percent is rounded so that 100/e is a power of two. The shift amount is the base-2 log of that ratio, so 25 % becomes a shift of 2 and 12.5 % a shift of 3.

The unit computes an error budget by shifting the operand right. A float's operand is its mantissa with the hidden 1 restored. The unit then finds the bit length n of the budget and clears the lowest n-1 bits of the operand. It also reports those positions as a don't-care mask. A float keeps its sign and exponent untouched. Words that are not approximable pass through unchanged. No multiplier, divider or floating-point operator is used, and one datapath serves both data types. The result is registered, so it appears one clock after the input is presented.

Top module: `approx_value_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from one cycle earlier. `out_word` and `out_mask` load only when `in_valid` is 1, and they hold their values in a cycle with `in_valid` at 0.
- R2: When `in_approx` is 0, the next `out_word` equals `in_word` and the next `out_mask` is 0, for either data type.
- R3: The operand is `in_word` as an unsigned integer when `in_is_float` is 0. When `in_is_float` is 1, it is `{8'b0, 1'b1, in_word[22:0]}`. The budget is `operand >> in_shift`, with the shift in the range 0 to 31.
- R4: Let n be the position of the highest set bit of the budget plus one. The mask has exactly its lowest n-1 bits set. A zero budget, which includes a zero integer input, gives a zero mask.
- R5: In the output, every position set in `out_mask` is 0. Every other position keeps its input value.
- R6: For an approximable integer, `in_word - out_word` is never larger than the budget.
- R7: For a float, `out_word[31:23]` equals `in_word[31:23]`. The sign is bit 31 and the exponent is bits 30..23. `out_mask[31:23]` is always 0, so the hidden-bit position is never a don't-care.
- R8: Under reset (`rst_n` low), `out_valid`, `out_word` and `out_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 32 | Data word to approximate |
| in_approx | input | 1 | 1: word may be approximated; 0: bypass |
| in_is_float | input | 1 | 1: single-precision float; 0: unsigned integer |
| in_shift | input | 5 | Error threshold as right-shift amount |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Approximated word |
| out_mask | output | 32 | Don't-care positions (1 = cleared bit) |

## Verification
The hardest cases to reach are the extremes of the budget's bit length. A budget of exactly 1 must give an empty mask. A zero shift on a float must make the mask run right up to bit 22 and stop there. A zero shift on an all-ones integer must give the widest mask, 31 bits. Random words rarely hit these combinations, so the stimulus sets them up directly. It uses words that are exact powers of two paired with a shift equal to their bit index, all-ones and all-zero mantissas with shift 0, and an integer of 1 with shift 0. A pseudo-random sweep over word, shift and type then follows, and every cycle is compared with a behavioural model.

// File: rtl/avu_pkg.sv
package avu_pkg;
  localparam int DATA_W  = 32;
  localparam int MANT_W  = 23;
  localparam int EXP_W   = 8;
  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int HEAD_W  = DATA_W - MANT_W;   // sign + exponent
  localparam int PAD_W   = DATA_W - MANT_W - 1;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SHIFT_W-1:0] shift_t;
endpackage

// File: rtl/avu_operand_sel.sv
module avu_operand_sel
  import avu_pkg::*;
(
  input  word_t in_word,
  input  logic  is_float,
  output word_t operand
);
  always_comb begin
    if (is_float) operand = {{PAD_W{1'b0}}, 1'b1, in_word[MANT_W-1:0]};
    else          operand = in_word;
  end
endmodule

// File: rtl/avu_dc_mask.sv
module avu_dc_mask #(
  parameter int W = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [SW-1:0] shift,
  output logic [W-1:0]  mask
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0] budget;
  logic [W-1:0] smear [0:STAGES];

  assign budget   = operand >> shift;
  assign smear[0] = budget;

  // Leading-one detect by smearing the top set bit downward.
  for (genvar s = 0; s < STAGES; s++) begin : g_smear
    assign smear[s+1] = smear[s] | (smear[s] >> (1 << s));
  end

  // smear holds n ones; the don't-care field is the lowest n-1 of them.
  assign mask = smear[STAGES] >> 1;

  always_comb begin
    a_mask_below_budget_r4: assert (budget == '0 ? mask == '0 : mask < budget);
  end
endmodule

// File: rtl/avu_merge.sv
module avu_merge
  import avu_pkg::*;
(
  input  word_t in_word,
  input  logic  approx,
  input  logic  is_float,
  input  word_t raw_mask,
  output word_t word_nx,
  output word_t mask_nx
);
  word_t clamped;

  always_comb begin
    if (is_float) clamped = {{HEAD_W{1'b0}}, raw_mask[MANT_W-1:0]};
    else          clamped = raw_mask;
  end

  always_comb begin
    if (!approx) begin
      word_nx = in_word;
      mask_nx = '0;
    end else begin
      word_nx = in_word & ~clamped;
      mask_nx = clamped;
    end
  end
endmodule

// File: rtl/approx_value_unit.sv
module approx_value_unit
  import avu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_word,
  input  logic              in_approx,
  input  logic              in_is_float,
  input  logic [SHIFT_W-1:0] in_shift,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic [DATA_W-1:0] out_mask
);
  word_t operand, raw_mask, word_nx, mask_nx;
  word_t word_q, mask_q, word_d, mask_d;
  logic  valid_q;

  avu_operand_sel u_sel (
    .in_word  (in_word),
    .is_float (in_is_float),
    .operand  (operand)
  );

  avu_dc_mask #(.W(DATA_W), .SW(SHIFT_W)) u_mask (
    .operand (operand),
    .shift   (in_shift),
    .mask    (raw_mask)
  );

  avu_merge u_merge (
    .in_word  (in_word),
    .approx   (in_approx),
    .is_float (in_is_float),
    .raw_mask (raw_mask),
    .word_nx  (word_nx),
    .mask_nx  (mask_nx)
  );

  // Next-state with explicit load enable.
  always_comb begin
    word_d = word_q;
    mask_d = mask_q;
    if (in_valid) begin
      word_d = word_nx;
      mask_d = mask_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= in_valid;
      word_q  <= word_d;
      mask_q  <= mask_d;
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;
  assign out_mask  = mask_q;

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_approx |=> out_word == $past(in_word) && out_mask == '0);

  p_cleared_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word & out_mask) == '0 &&
                 (out_word | out_mask) == ($past(in_word) | out_mask));

  p_float_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_is_float |=> out_word[DATA_W-1:MANT_W] == $past(in_word[DATA_W-1:MANT_W])
                                && out_mask[DATA_W-1:MANT_W] == '0);

  p_err_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_approx && !in_is_float |=>
      ($past(in_word) - out_word) <= ($past(in_word) >> $past(in_shift)));

  p_contig_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask + 1'b1) & out_mask) == '0);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word) && $stable(out_mask) && !out_valid);
endmodule

// File: tb/approx_value_unit_tb.sv
module approx_value_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_approx;
  logic        in_is_float;
  logic [4:0]  in_shift;
  logic        out_valid;
  logic [31:0] out_word;
  logic [31:0] out_mask;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  approx_value_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_approx(in_approx), .in_is_float(in_is_float), .in_shift(in_shift),
    .out_valid(out_valid), .out_word(out_word), .out_mask(out_mask)
  );

  function automatic logic [63:0] model(input logic [31:0] w, input bit a,
                                        input bit f, input int s);
    longint unsigned op, bud, msk;
    int top;
    logic [31:0] rw;
    if (!a) return {w, 32'h0};
    op  = f ? (64'h80_0000 | longint'(w[22:0])) : longint'(w);
    bud = op >> s;
    top = -1;
    for (int i = 0; i < 32; i++) if (bud[i]) top = i;
    msk = (top <= 0) ? 0 : ((64'd1 << top) - 1);
    if (f) msk = msk & 64'h7F_FFFF;
    rw = w & ~msk[31:0];
    return {rw, msk[31:0]};
  endfunction

  task automatic note(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input bit a, input bit f, input int s);
    logic [63:0] e;
    longint unsigned bud;
    e = model(w, a, f, s);
    @(negedge clk);
    in_valid = 1; in_word = w; in_approx = a; in_is_float = f; in_shift = s[4:0];
    @(negedge clk);
    in_valid = 0;
    note("R1 out_valid", {31'b0, out_valid}, 32'd1);
    note(a ? (f ? "R7/R5 float word" : "R4/R5 int word") : "R2 bypass word",
         out_word, e[63:32]);
    note(a ? "R3/R4 mask" : "R2 bypass mask", out_mask, e[31:0]);
    if (a && !f) begin
      bud = longint'(w) >> s;
      checks++;
      if (longint'(w) - longint'(out_word) > bud) begin
        fails++;
        $display("FAIL R6 error=%0d budget=%0d", longint'(w) - longint'(out_word), bud);
      end
    end
    if (f) note("R7 sign/exponent", {23'b0, out_word[31:23]}, {23'b0, w[31:23]});
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] hw, hm;
    rst_n = 0; in_valid = 0; in_word = 0; in_approx = 0; in_is_float = 0; in_shift = 0;
    repeat (3) @(negedge clk);
    note("R8 reset valid", {31'b0, out_valid}, 32'd0);
    note("R8 reset word", out_word, 32'd0);
    note("R8 reset mask", out_mask, 32'd0);
    rst_n = 1;

    apply(32'h0000_0064, 1, 0, 2);   // 100 at 25%: budget 25, mask 0xF
    apply(32'h0000_0000, 1, 0, 0);   // zero input R4
    apply(32'h0000_0001, 1, 0, 0);   // budget 1 -> empty mask R4
    apply(32'hFFFF_FFFF, 1, 0, 0);   // widest integer mask
    apply(32'h0000_0400, 1, 0, 10);  // budget exactly 1
    apply(32'h0000_0800, 1, 0, 10);  // budget 2 -> mask 1
    apply(32'h8000_0000, 1, 0, 31);
    apply(32'h0000_00FF, 1, 0, 9);   // zero budget
    apply(32'hDEAD_BEEF, 0, 0, 0);   // bypass int R2
    apply(32'hC0FF_EE11, 0, 1, 0);   // bypass float R2
    apply(32'h3F80_0000, 1, 1, 0);   // float, mask bits 22..0 R7
    apply(32'hBF7F_FFFF, 1, 1, 0);   // all-ones mantissa
    apply(32'h4049_0FDB, 1, 1, 3);
    apply(32'h7F7F_FFFF, 1, 1, 23);  // budget 1 -> no change
    apply(32'h0000_0000, 1, 1, 22);  // zero mantissa, budget 2

    // R1: hold while in_valid is low.
    apply(32'h1234_5678, 1, 0, 4);
    hw = out_word; hm = out_mask;
    @(negedge clk);
    in_word = 32'hFFFF_FFFF; in_approx = 1; in_shift = 0;
    @(negedge clk);
    note("R1 hold word", out_word, hw);
    note("R1 hold mask", out_mask, hm);
    note("R1 valid low", {31'b0, out_valid}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w, c;
      rng = nxt(rng); w = rng;
      rng = nxt(rng); c = rng;
      if (c[9]) w = w >> c[14:10];
      apply(w, c[0] | c[1], c[2], int'(c[7:3]));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule